// File: doc/BRIEF.md
# Keyboard Matrix Emulator with Rate-Limited Event Queue

This block stands in for the physical key matrix of a small handheld keyboard, as seen by a scanning controller. The controller drives a vector of column strobes and reads back one sense line per row. Key events arrive as 8-bit codes: bit 7 set means release, and the low seven bits name the key. Each event is held in a 16-entry circular queue. Events leave the queue one at a time, on a slow periodic tick, and each one updates a per-row mask of pressed keys.

A sense line is active whenever its row mask and the live strobe vector have a bit in common. It follows strobe changes in the same cycle. Keys that map to the extra row with index 7 do not touch the matrix. They drive five discrete switch outputs instead, such as a lid switch or a power button. A restore request drops all pressed keys and empties the queue, for use after a saved state is reloaded.

Top module: `keymatrix_emu`

## Requirements
- R1: Each sense bit r equals the OR-reduction of (row r pressed mask AND strobe_i), evaluated combinationally on the live strobe vector. With no strobe active, every sense bit is 0.
- R2: Key index k (evt_code_i[6:0]) below 77 maps to row k/11 and column k%11. A dequeued event with bit 7 clear sets that key's bit in its row mask. With bit 7 set, it clears the bit.
- R3: Key indices 77 to 81 select switch output k-77. A dequeued press drives that output to 1 and a release drives it to 0. The row masks are left unchanged.
- R4: Key indices 82 to 127 are unmapped. Dequeuing them changes neither the matrix nor the switch outputs.
- R5: At most one queued event is applied per tick, and ticks occur every TICK_DIV clock cycles. Two events queued back to back take effect exactly TICK_DIV cycles apart.
- R6: The queue holds up to 16 events and releases them in arrival order. An event offered while the queue is full is dropped, and overflow_o sets and stays set.
- R7: A one-cycle restore_i pulse clears all row masks, empties the queue, clears overflow_o and restarts the tick phase. The switch outputs keep their values.
- R8: After reset, all sense bits, switch outputs and overflow_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restore_i | input | 1 | Restore pulse: release all keys, flush queue |
| evt_valid_i | input | 1 | Key event offered this cycle |
| evt_code_i | input | 8 | Event code: bit 7 release, bits 6:0 key index |
| strobe_i | input | 11 | Column strobe vector from the scanner |
| sense_o | output | 7 | Row sense lines |
| switch_o | output | 5 | Discrete switch outputs |
| overflow_o | output | 1 | Sticky queue-overflow flag |

## Verification
The bench presses every matrix key in turn and releases a subset. After each step it sweeps one-hot and mixed strobe patterns, so a wrong row/column split or a swapped sense bit shows up as a mismatch against the arithmetic model. It fills the queue right after a restore, so that no tick can intervene. This exposes a queue that accepts a seventeenth entry, loses its order, or fails to latch overflow. Two back-to-back presses are timed to the cycle: a design that drains several entries per tick, or runs the tick at the wrong divisor, misses the spacing. Switch keys, unmapped keys and a restore with events in flight are checked for leaking into the matrix, leaving the switches disturbed, or letting queued presses survive.

// File: rtl/kme_pkg.sv
// Package: shared types for the keyboard matrix emulator.
// Assumes at most 16 columns and 15 rows, since the location fields are 4 bits.
package kme_pkg;
    localparam int EVT_W = 8;
    localparam int KEY_W = 7;

    // Decoded key location: valid flag, row index, column index
    typedef struct packed {
        logic       ok;
        logic [3:0] row;
        logic [3:0] col;
    } kloc_t;
endpackage

// File: rtl/kme_ticker.sv
// Module: periodic tick generator.
// Emits a one-cycle pulse every DIV cycles. restart_i puts the phase back to zero.
// Assumes DIV >= 1.
module kme_ticker #(
    parameter int DIV = 1562500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick_o = (cnt == CW'(DIV - 1));

    // Free-running modulo-DIV counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || tick_o) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/kme_fifo.sv
// Module: circular event queue.
// Pushes into a full queue are dropped and set a sticky overflow flag.
// flush_i empties the queue, clears the flag and overrides push and pop.
// Assumes pop_i is raised only when the caller wants the head entry consumed.
module kme_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);
    assign push_ok = push_i && !full && !flush_i;
    assign pop_ok  = pop_i && !empty_o && !flush_i;
    assign dout_o  = mem[rp];

    // Storage write; entries need no reset
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din_i;
    end

    // Pointers, occupancy and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            ovf_o <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
            if (push_i && full) ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/kme_keymap.sv
// Module: key index to matrix location.
// Indices below ROWS*COLS fill the matrix row by row. The next SW indices land
// in the extra row ROWS, one column per switch. The remaining indices are invalid.
// Assumes ROWS*COLS+SW <= 128.
module kme_keymap
    import kme_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int COLS = 11,
    parameter int SW   = 5
) (
    input  logic [KEY_W-1:0] key_i,
    output kloc_t            loc_o
);
    localparam int MAT = ROWS * COLS;

    // Arithmetic lookup: no stored table
    always_comb begin
        int k;
        k = int'(key_i);
        loc_o = '0;
        if (k < MAT) begin
            loc_o.ok  = 1'b1;
            loc_o.row = 4'(k / COLS);
            loc_o.col = 4'(k % COLS);
        end else if (k < MAT + SW) begin
            loc_o.ok  = 1'b1;
            loc_o.row = 4'(ROWS);
            loc_o.col = 4'(k - MAT);
        end
    end
endmodule

// File: rtl/kme_matrix.sv
// Module: per-row pressed masks, sense generation and switch outputs.
// An applied event updates one row bit, or one switch when its row equals ROWS.
// clear_i drops every row mask and leaves the switches alone.
module kme_matrix
    import kme_pkg::*;
#(
    parameter int ROWS = 7,
    parameter int COLS = 11,
    parameter int SW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            apply_i,
    input  logic            release_i,
    input  kloc_t           loc_i,
    input  logic [COLS-1:0] strobe_i,
    output logic [ROWS-1:0] sense_o,
    output logic [SW-1:0]   sw_o
);
    logic [COLS-1:0] colsel;

    assign colsel = COLS'(1) << loc_i.col;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] mask;
        logic            hit;

        assign hit = apply_i && loc_i.ok && (loc_i.row == 4'(r));

        // Row mask: set on press, clear on release, drop on clear
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) mask <= '0;
            else if (hit)          mask <= release_i ? (mask & ~colsel) : (mask | colsel);
        end

        // Sense follows the live strobe vector
        assign sense_o[r] = |(mask & strobe_i);
    end

    for (genvar s = 0; s < SW; s++) begin : g_sw
        // Switch level follows press/release of its extra-row key
        always_ff @(posedge clk) begin
            if (!rst_n) sw_o[s] <= 1'b0;
            else if (apply_i && loc_i.ok && loc_i.row == 4'(ROWS) && loc_i.col == 4'(s))
                sw_o[s] <= !release_i;
        end
    end
endmodule

// File: rtl/keymatrix_emu.sv
// Module: keyboard matrix emulator top level.
// Events are queued and then applied one per tick to the matrix or the switches.
// A restore pulse releases all keys, empties the queue and restarts the tick.
// Assumes evt_code_i is stable whenever evt_valid_i is high.
module keymatrix_emu
    import kme_pkg::*;
#(
    parameter int NUM_ROWS   = 7,
    parameter int NUM_COLS   = 11,
    parameter int NUM_SW     = 5,
    parameter int FIFO_DEPTH = 16,
    parameter int TICK_DIV   = 1562500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restore_i,
    input  logic                evt_valid_i,
    input  logic [EVT_W-1:0]    evt_code_i,
    input  logic [NUM_COLS-1:0] strobe_i,
    output logic [NUM_ROWS-1:0] sense_o,
    output logic [NUM_SW-1:0]   switch_o,
    output logic                overflow_o
);
    logic             tick, empty, pop;
    logic [EVT_W-1:0] head;
    kloc_t            loc;

    assign pop = tick && !empty && !restore_i;

    kme_ticker #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart_i(restore_i), .tick_o(tick)
    );

    kme_fifo #(.DEPTH(FIFO_DEPTH), .W(EVT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush_i(restore_i),
        .push_i(evt_valid_i), .din_i(evt_code_i), .pop_i(pop),
        .dout_o(head), .empty_o(empty), .ovf_o(overflow_o)
    );

    kme_keymap #(.ROWS(NUM_ROWS), .COLS(NUM_COLS), .SW(NUM_SW)) u_map (
        .key_i(head[KEY_W-1:0]), .loc_o(loc)
    );

    kme_matrix #(.ROWS(NUM_ROWS), .COLS(NUM_COLS), .SW(NUM_SW)) u_mtx (
        .clk(clk), .rst_n(rst_n), .clear_i(restore_i), .apply_i(pop),
        .release_i(head[EVT_W-1]), .loc_i(loc), .strobe_i(strobe_i),
        .sense_o(sense_o), .sw_o(switch_o)
    );
endmodule

// File: rtl/kme_checker.sv
// Module: protocol checker for keymatrix_emu, attached by bind.
// Observes the ports and the internal tick strobe.
module kme_checker #(
    parameter int ROWS = 7,
    parameter int COLS = 11,
    parameter int SW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            restore_i,
    input logic [COLS-1:0] strobe_i,
    input logic [ROWS-1:0] sense_o,
    input logic [SW-1:0]   switch_o,
    input logic            overflow_o,
    input logic            tick_i
);
    logic pv;

    // Marks that one cycle out of reset has passed, so $past is meaningful
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    assert_no_strobe_no_sense_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '0) |-> (sense_o == '0));

    assert_one_switch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pv |-> ($countones(switch_o ^ $past(switch_o)) <= 1));

    assert_switch_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && (switch_o != $past(switch_o))) |-> $past(tick_i));

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !restore_i) |=> overflow_o);

    assert_restore_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> ((sense_o == '0) && !overflow_o));

    assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((switch_o == '0) && !overflow_o && (sense_o == '0)));
endmodule

bind keymatrix_emu kme_checker #(.ROWS(NUM_ROWS), .COLS(NUM_COLS), .SW(NUM_SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .restore_i(restore_i), .strobe_i(strobe_i),
    .sense_o(sense_o), .switch_o(switch_o), .overflow_o(overflow_o), .tick_i(tick)
);

// File: tb/keymatrix_emu_tb.sv
// Bench for keymatrix_emu: short tick divisor, arithmetic model of the matrix.
module keymatrix_emu_tb;
    localparam int R   = 7;
    localparam int C   = 11;
    localparam int SW  = 5;
    localparam int DIV = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restore = 1'b0;
    logic         evt_valid = 1'b0;
    logic [7:0]   evt_code = '0;
    logic [C-1:0] strobe = '0;
    logic [R-1:0] sense;
    logic [SW-1:0] sw;
    logic         ovf;

    int checks = 0;
    int errors = 0;

    logic [C-1:0]  em [R];
    logic [SW-1:0] esw;

    always #10 clk = ~clk;

    keymatrix_emu #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .restore_i(restore), .evt_valid_i(evt_valid),
        .evt_code_i(evt_code), .strobe_i(strobe), .sense_o(sense),
        .switch_o(sw), .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [R-1:0] exp_sense(input logic [C-1:0] pat);
        logic [R-1:0] v;
        for (int r = 0; r < R; r++) v[r] = |(em[r] & pat);
        return v;
    endfunction

    task automatic set_key(input int k, input bit pressed);
        if (k < R * C) em[k / C][k % C] = pressed;
        else if (k < R * C + SW) esw[k - R * C] = pressed;
    endtask

    task automatic check_matrix(input string req);
        logic [C-1:0] pats [3];
        pats[0] = '0; pats[1] = 11'h555; pats[2] = '1;
        for (int c = 0; c < C; c++) begin
            @(negedge clk); strobe = C'(1) << c; #2;
            chk(sense == exp_sense(strobe), req, $sformatf("sense col %0d", c),
                int'(sense), int'(exp_sense(strobe)));
        end
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); strobe = pats[p]; #2;
            chk(sense == exp_sense(strobe), req, "sense pattern",
                int'(sense), int'(exp_sense(strobe)));
        end
        chk(sw == esw, "R3", "switch outputs", int'(sw), int'(esw));
    endtask

    task automatic push(input logic [7:0] code);
        @(negedge clk); evt_valid = 1'b1; evt_code = code;
    endtask

    task automatic end_push();
        @(negedge clk); evt_valid = 1'b0;
    endtask

    task automatic do_restore();
        @(negedge clk); evt_valid = 1'b0; restore = 1'b1;
        @(negedge clk); restore = 1'b0;
        for (int r = 0; r < R; r++) em[r] = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int t0, t1;
        for (int r = 0; r < R; r++) em[r] = '0;
        esw = '0;
        settle(4);
        @(negedge clk); rst_n = 1'b1;
        // R8: state right after reset
        @(negedge clk); strobe = '1; #2;
        chk(sense == '0, "R8", "sense after reset", int'(sense), 0);
        chk(sw == '0, "R8", "switches after reset", int'(sw), 0);
        chk(ovf == 1'b0, "R8", "overflow after reset", int'(ovf), 0);

        // R6: fill queue right after restore (no tick can occur), 17th dropped
        do_restore();
        for (int k = 0; k < 17; k++) push(8'(k));
        end_push();
        #2;
        chk(ovf == 1'b1, "R6", "overflow after 17 pushes", int'(ovf), 1);
        for (int k = 0; k < 16; k++) set_key(k, 1'b1);
        settle(17 * DIV + 4);
        check_matrix("R6");
        chk(ovf == 1'b1, "R6", "overflow sticky", int'(ovf), 1);

        // R7: restore clears masks and overflow
        do_restore(); #2;
        chk(ovf == 1'b0, "R7", "overflow after restore", int'(ovf), 0);
        check_matrix("R7");

        // R5: two back-to-back presses take effect DIV cycles apart
        do_restore();
        @(negedge clk); strobe = '1;
        push(8'd0); push(8'd11); end_push();
        t0 = -1; t1 = -1;
        for (int i = 1; i <= 4 * DIV; i++) begin
            @(negedge clk); #2;
            if (sense[0] && t0 < 0) t0 = i;
            if (sense[1] && t1 < 0) t1 = i;
        end
        chk(t0 > 0 && t0 <= DIV + 2, "R5", "first apply latency", t0, DIV);
        chk(t1 - t0 == DIV, "R5", "spacing between events", t1 - t0, DIV);
        set_key(0, 1'b1); set_key(11, 1'b1);

        // R2: release clears a bit
        push(8'h80); end_push();
        set_key(0, 1'b0);
        settle(2 * DIV + 2);
        check_matrix("R2");

        // R2 / R1: press every matrix key in turn, then release every third
        for (int k = 0; k < R * C; k++) begin
            push(8'(k)); end_push();
            settle(DIV + 1);
            set_key(k, 1'b1);
        end
        check_matrix("R2");
        for (int k = 0; k < R * C; k += 3) begin
            push(8'(k) | 8'h80); end_push();
            settle(DIV + 1);
            set_key(k, 1'b0);
        end
        check_matrix("R1");

        // R3: switch keys change only their outputs
        for (int j = 0; j < SW; j++) begin
            push(8'(R * C + j)); end_push();
            settle(DIV + 2);
            set_key(R * C + j, 1'b1);
            check_matrix("R3");
        end
        for (int j = 0; j < SW; j += 2) begin
            push(8'(R * C + j) | 8'h80); end_push();
            settle(DIV + 2);
            set_key(R * C + j, 1'b0);
        end
        check_matrix("R3");

        // R4: unmapped keys have no effect
        push(8'd100); push(8'd127); push(8'd82 | 8'h80); push(8'hFF); end_push();
        settle(5 * DIV + 2);
        check_matrix("R4");

        // R7: restore with events in flight; switches keep their levels
        push(8'd20); push(8'd30); push(8'd40);
        do_restore();
        settle(5 * DIV);
        check_matrix("R7");
        chk(sw == esw, "R7", "switches kept over restore", int'(sw), int'(esw));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule